// File: doc/BRIEF.md
# BCD Calendar Time Counter

This block holds the time of day and the calendar date in packed BCD registers: seconds, minutes, hours, date, month, a two-digit year and a day-of-week index. A one-cycle `tick_i` pulse, produced elsewhere once per second, advances the seconds. Each field that wraps carries into the next field up the chain, and the date logic knows the length of every month, including a leap February.

The hour register holds its own format. Bit 7 selects 24-hour counting. In 12-hour mode, bit 5 marks the afternoon. A host write port loads any single register directly, and `day_carry_o` pulses whenever the time rolls past midnight. The host reads every register from the output ports at all times.

Top module: `bcd_rtc_core`

## Requirements
- R1: After reset, seconds, minutes and year read 00, the hour register reads 8'h12 (12-hour mode, AM, hour 12), date and month read 01, day of week reads 0 and `day_carry_o` is 0.
- R2: Each clock with `tick_i` high advances seconds by one in BCD. Seconds wrap from 59 to 00. That wrap advances minutes, which also count 00 to 59 and wrap.
- R3: With hour bit 7 set, the hour field (bits 5:0) counts BCD 00 to 23 on each minute wrap. 23 wraps to 00 and advances the date.
- R4: With hour bit 7 clear, the hour field (bits 4:0) runs 12, 01, ..., 11, and bit 5 is the PM flag (1 = PM). The flag toggles on the step from 11 to 12, 12 steps to 01 with the flag kept, and the date advances only on 11 PM to 12 AM.
- R5: Months 01, 03, 05, 07, 08, 10 and 12 end on day 31, and months 04, 06, 09 and 11 end on day 30. Past the last day, the date returns to 01 and the month advances. Month 12 wraps to 01 and advances the year, and year 99 wraps to 00.
- R6: February ends on day 29 when the binary value of the year is divisible by 4 (year 00 included), and on day 28 otherwise.
- R7: Day of week counts 0 to 6 and wraps to 0. It advances once at every date advance.
- R8: `day_carry_o` is high for exactly the one cycle in which the outputs first show the midnight rollover, and low otherwise.
- R9: With `wr_en_i` high, `wr_sel_i` picks the register: 0 seconds, 1 minutes, 2 hour, 3 date, 4 month, 5 year, 6 day of week. Select 7 writes nothing. The data is stored at the next clock, masked to 7'h7F for seconds and minutes, 8'hBF for hour, 6'h3F for date, 5'h1F for month, 3 bits for day of week, and all 8 bits for year. For that register it replaces the tick increment, while carries out of the written register's old value still advance the others.
- R10: Without a tick or a write, no output changes and `day_carry_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-second advance enable |
| wr_en_i | input | 1 | Host write strobe |
| wr_sel_i | input | 3 | Register select for the write |
| wr_data_i | input | 8 | Write data, packed BCD |
| sec_o | output | 8 | Seconds, BCD |
| min_o | output | 8 | Minutes, BCD |
| hour_o | output | 8 | Hour register: mode bit 7, PM bit 5, BCD hour |
| date_o | output | 8 | Day of month, BCD |
| month_o | output | 8 | Month, BCD |
| year_o | output | 8 | Two-digit year, BCD |
| dow_o | output | 3 | Day of week 0..6 |
| day_carry_o | output | 1 | One-cycle pulse at midnight rollover |

## Verification
Directed cases place the clock one second before midnight on chosen dates. Feb 28 in year 00 and in year 01 separate the leap rule from a fixed February. Apr 30 and Dec 31 in year 99 exercise the 30-day and year-end cascades. Both 11 PM and 11 AM are run in 12-hour mode, which shows whether the PM flag and the date carry are keyed to the right half of the day. A write that lands on the same cycle as a seconds wrap tells the override apart from a lost carry. Random ticks and writes, biased toward field maxima, are compared every cycle against a binary-arithmetic model and reach mixed-mode rollovers that the directed cases miss.

// File: rtl/bcd_rtc_pkg.sv
package bcd_rtc_pkg;
  localparam int unsigned RW = 8;
  localparam int unsigned NREG = 7;

  typedef enum logic [2:0] {
    SEL_SEC  = 3'd0,
    SEL_MIN  = 3'd1,
    SEL_HOUR = 3'd2,
    SEL_DATE = 3'd3,
    SEL_MON  = 3'd4,
    SEL_YEAR = 3'd5,
    SEL_DOW  = 3'd6
  } rtc_sel_e;

  function automatic logic [RW-1:0] bcd_inc(input logic [RW-1:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic year_is_leap(input logic [RW-1:0] y);
    logic [6:0] b;
    b = 7'(y[7:4]) * 7'd10 + 7'(y[3:0]);
    return b[1:0] == 2'b00;
  endfunction

  function automatic logic [RW-1:0] month_last_day(input logic [RW-1:0] mo,
                                                   input logic [RW-1:0] y);
    case (mo)
      8'h02:                      return year_is_leap(y) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/bcd_wrap_counter.sv
module bcd_wrap_counter
  import bcd_rtc_pkg::*;
#(
  parameter logic [RW-1:0] LOW     = 8'h00,
  parameter logic [RW-1:0] RST_VAL = 8'h00,
  parameter logic [RW-1:0] WR_MASK = 8'hFF
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          inc_i,
  input  logic [RW-1:0] lim_i,
  input  logic          ld_i,
  input  logic [RW-1:0] ld_val_i,
  output logic [RW-1:0] q_o
);
  logic [RW-1:0] q, nxt;

  always_comb begin
    nxt = q;
    if (ld_i)       nxt = ld_val_i & WR_MASK;
    else if (inc_i) nxt = (q >= lim_i) ? LOW : bcd_inc(q);
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) q <= RST_VAL;
    else         q <= nxt;

  assign q_o = q;
endmodule

// File: rtl/bcd_hour_counter.sv
module bcd_hour_counter
  import bcd_rtc_pkg::*;
#(
  parameter logic [RW-1:0] RST_VAL = 8'h12,
  parameter logic [RW-1:0] WR_MASK = 8'hBF
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          inc_i,
  input  logic          ld_i,
  input  logic [RW-1:0] ld_val_i,
  output logic [RW-1:0] q_o,
  output logic          last_o
);
  logic [RW-1:0] q, nxt, h24_inc, h12_inc;
  logic          mode24, pm;

  assign mode24 = q[7];
  assign pm     = q[5];
  assign h24_inc = bcd_inc({2'b00, q[5:0]});
  assign h12_inc = bcd_inc({3'b000, q[4:0]});

  // last hour of the day in either format
  assign last_o = mode24 ? (q[5:0] == 6'h23) : (pm && q[4:0] == 5'h11);

  always_comb begin
    nxt = q;
    if (ld_i) begin
      nxt = ld_val_i & WR_MASK;
    end else if (inc_i) begin
      if (mode24) begin
        nxt = (q[5:0] == 6'h23) ? 8'h80 : {2'b10, h24_inc[5:0]};
      end else if (q[4:0] == 5'h11) begin
        nxt = {2'b00, ~pm, 5'h12};
      end else if (q[4:0] == 5'h12) begin
        nxt = {2'b00, pm, 5'h01};
      end else begin
        nxt = {2'b00, pm, h12_inc[4:0]};
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) q <= RST_VAL;
    else         q <= nxt;

  assign q_o = q;
endmodule

// File: rtl/bcd_rtc_core.sv
module bcd_rtc_core
  import bcd_rtc_pkg::*;
#(
  parameter int unsigned DOW_N = 7,
  localparam int unsigned DOW_W = $clog2(DOW_N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             wr_en_i,
  input  logic [2:0]       wr_sel_i,
  input  logic [RW-1:0]    wr_data_i,
  output logic [RW-1:0]    sec_o,
  output logic [RW-1:0]    min_o,
  output logic [RW-1:0]    hour_o,
  output logic [RW-1:0]    date_o,
  output logic [RW-1:0]    month_o,
  output logic [RW-1:0]    year_o,
  output logic [DOW_W-1:0] dow_o,
  output logic             day_carry_o
);
  logic [NREG-1:0] ld;
  logic [RW-1:0]   sec_q, min_q, hour_q, date_q, mon_q, year_q, last_day;
  logic            hour_last;
  logic            c_min, c_hr, c_day, c_mon, c_yr;
  logic [DOW_W-1:0] dow_q;
  logic            carry_q;

  for (genvar i = 0; i < NREG; i++) begin : g_ld
    assign ld[i] = wr_en_i && (wr_sel_i == 3'(i));
  end

  // carry chain uses current register values, independent of writes
  assign last_day = month_last_day(mon_q, year_q);
  assign c_min = tick_i && (sec_q >= 8'h59);
  assign c_hr  = c_min && (min_q >= 8'h59);
  assign c_day = c_hr && hour_last;
  assign c_mon = c_day && (date_q >= last_day);
  assign c_yr  = c_mon && (mon_q >= 8'h12);

  bcd_wrap_counter #(.LOW(8'h00), .RST_VAL(8'h00), .WR_MASK(8'h7F)) u_sec (
    .clk_i, .rst_ni, .inc_i(tick_i), .lim_i(8'h59),
    .ld_i(ld[SEL_SEC]), .ld_val_i(wr_data_i), .q_o(sec_q));

  bcd_wrap_counter #(.LOW(8'h00), .RST_VAL(8'h00), .WR_MASK(8'h7F)) u_min (
    .clk_i, .rst_ni, .inc_i(c_min), .lim_i(8'h59),
    .ld_i(ld[SEL_MIN]), .ld_val_i(wr_data_i), .q_o(min_q));

  bcd_hour_counter #(.RST_VAL(8'h12), .WR_MASK(8'hBF)) u_hour (
    .clk_i, .rst_ni, .inc_i(c_hr),
    .ld_i(ld[SEL_HOUR]), .ld_val_i(wr_data_i), .q_o(hour_q), .last_o(hour_last));

  bcd_wrap_counter #(.LOW(8'h01), .RST_VAL(8'h01), .WR_MASK(8'h3F)) u_date (
    .clk_i, .rst_ni, .inc_i(c_day), .lim_i(last_day),
    .ld_i(ld[SEL_DATE]), .ld_val_i(wr_data_i), .q_o(date_q));

  bcd_wrap_counter #(.LOW(8'h01), .RST_VAL(8'h01), .WR_MASK(8'h1F)) u_mon (
    .clk_i, .rst_ni, .inc_i(c_mon), .lim_i(8'h12),
    .ld_i(ld[SEL_MON]), .ld_val_i(wr_data_i), .q_o(mon_q));

  bcd_wrap_counter #(.LOW(8'h00), .RST_VAL(8'h00), .WR_MASK(8'hFF)) u_year (
    .clk_i, .rst_ni, .inc_i(c_yr), .lim_i(8'h99),
    .ld_i(ld[SEL_YEAR]), .ld_val_i(wr_data_i), .q_o(year_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dow_q   <= '0;
      carry_q <= 1'b0;
    end else begin
      carry_q <= c_day;
      if (ld[SEL_DOW])
        dow_q <= wr_data_i[DOW_W-1:0];
      else if (c_day)
        dow_q <= (dow_q >= DOW_W'(DOW_N - 1)) ? '0 : dow_q + 1'b1;
    end
  end

  assign sec_o       = sec_q;
  assign min_o       = min_q;
  assign hour_o      = hour_q;
  assign date_o      = date_q;
  assign month_o     = mon_q;
  assign year_o      = year_q;
  assign dow_o       = dow_q;
  assign day_carry_o = carry_q;
endmodule

// File: rtl/bcd_rtc_chk.sv
module bcd_rtc_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tick_i,
  input logic       wr_en_i,
  input logic [2:0] wr_sel_i,
  input logic [7:0] wr_data_i,
  input logic [7:0] sec_o,
  input logic [7:0] min_o,
  input logic [7:0] hour_o,
  input logic [7:0] date_o,
  input logic [7:0] month_o,
  input logic [7:0] year_o,
  input logic [2:0] dow_o,
  input logic       day_carry_o
);
  AST_DOW_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    day_carry_o && !$past(wr_en_i && wr_sel_i == 3'd6) |->
      dow_o == (($past(dow_o) == 3'd6) ? 3'd0 : $past(dow_o) + 3'd1)); // R7

  AST_MIDNIGHT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    day_carry_o && !$past(wr_en_i) |->
      sec_o == 8'h00 && min_o == 8'h00 && (hour_o == 8'h12 || hour_o == 8'h80)); // R8

  AST_CARRY_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    day_carry_o |=> !day_carry_o); // R8

  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(tick_i) && !$past(wr_en_i) |->
      $stable(sec_o) && $stable(min_o) && $stable(hour_o) && $stable(date_o) &&
      $stable(month_o) && $stable(year_o) && $stable(dow_o) && !day_carry_o); // R10

  AST_PM_TOGGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(wr_en_i) && !$past(hour_o[7]) && $past(hour_o[4:0]) == 5'h11 &&
      hour_o[4:0] == 5'h12 |-> hour_o[5] != $past(hour_o[5])); // R4

  AST_WRITE_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(wr_en_i && wr_sel_i == 3'd5) |-> year_o == $past(wr_data_i)); // R9
endmodule

bind bcd_rtc_core bcd_rtc_chk u_chk (.*);

// File: tb/sim_bcd_rtc_core.sv
module sim_bcd_rtc_core;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [2:0] wr_sel_i = 3'd0;
  logic [7:0] wr_data_i = 8'h00;
  logic [7:0] sec_o, min_o, hour_o, date_o, month_o, year_o;
  logic [2:0] dow_o;
  logic       day_carry_o;

  int n_chk = 0;
  int n_bad = 0;

  // reference state, binary
  int ms, mm, mh, md, mmo, my, mdw;
  bit mpm, mmode, mcarry;

  always #10 clk_i = ~clk_i;

  bcd_rtc_core u0 (.*);

  function automatic logic [7:0] i2bcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int bcd2i(input logic [7:0] b);
    return int'(b[7:4]) * 10 + int'(b[3:0]);
  endfunction

  function automatic int dim(input int mo, input int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  function automatic logic [7:0] hr_enc();
    logic [7:0] t;
    t = i2bcd(mh);
    if (mmode) return 8'h80 | t;
    return {2'b00, mpm, t[4:0]};
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic model_step(input bit tk, input bit we, input int sel, input logic [7:0] val);
    bit c;
    mcarry = 0;
    if (tk) begin
      c = 0;
      if (ms >= 59) begin ms = 0; c = 1; end else ms++;
      if (c) begin
        c = 0;
        if (mm >= 59) begin mm = 0; c = 1; end else mm++;
      end
      if (c) begin
        c = 0;
        if (mmode) begin
          if (mh >= 23) begin mh = 0; c = 1; end else mh++;
        end else if (mh == 11) begin
          mh = 12;
          if (mpm) c = 1;
          mpm = !mpm;
        end else if (mh == 12) mh = 1;
        else mh++;
      end
      if (c) begin
        mcarry = 1;
        mdw = (mdw == 6) ? 0 : mdw + 1;
        if (md >= dim(mmo, my)) begin
          md = 1;
          if (mmo >= 12) begin
            mmo = 1;
            my = (my >= 99) ? 0 : my + 1;
          end else mmo++;
        end else md++;
      end
    end
    if (we) begin
      case (sel)
        0: ms = bcd2i(val & 8'h7F);
        1: mm = bcd2i(val & 8'h7F);
        2: begin
          mmode = val[7];
          if (mmode) mh = bcd2i({2'b00, val[5:0]});
          else begin mpm = val[5]; mh = bcd2i({3'b000, val[4:0]}); end
        end
        3: md  = bcd2i(val & 8'h3F);
        4: mmo = bcd2i(val & 8'h1F);
        5: my  = bcd2i(val);
        6: mdw = int'(val[2:0]);
        default: ;
      endcase
    end
  endtask

  task automatic compare_all();
    chk("R2 sec", sec_o, i2bcd(ms));
    chk("R2 min", min_o, i2bcd(mm));
    chk("R3/R4 hour", hour_o, hr_enc());
    chk("R5 date", date_o, i2bcd(md));
    chk("R5 month", month_o, i2bcd(mmo));
    chk("R5 year", year_o, i2bcd(my));
    chk("R7 dow", {5'b0, dow_o}, 8'(mdw));
    chk("R8 carry", {7'b0, day_carry_o}, {7'b0, mcarry});
  endtask

  // called at a negedge; returns at the following negedge after checking
  task automatic cyc(input bit tk, input bit we, input int sel, input logic [7:0] val);
    tick_i = tk; wr_en_i = we; wr_sel_i = 3'(sel); wr_data_i = val;
    @(posedge clk_i);
    model_step(tk, we, sel, val);
    @(negedge clk_i);
    compare_all();
    tick_i = 0; wr_en_i = 0;
  endtask

  task automatic setr(input int sel, input logic [7:0] val);
    cyc(0, 1, sel, val);
  endtask

  task automatic edge_at(input logic [7:0] hr);
    setr(2, hr); setr(1, 8'h59); setr(0, 8'h59);
  endtask

  function automatic logic [7:0] rnd_val(input int sel);
    int r;
    r = $urandom % 3;
    case (sel)
      0, 1: return i2bcd(r == 0 ? 59 : int'($urandom % 60));
      2: if ($urandom % 2) return 8'h80 | i2bcd(r == 0 ? 23 : int'($urandom % 24));
         else begin
           logic [7:0] t;
           t = i2bcd(r == 0 ? 11 : int'($urandom % 12) + 1);
           return {2'b00, 1'($urandom % 2), t[4:0]};
         end
      3: return i2bcd(r == 0 ? 28 + int'($urandom % 4) : int'($urandom % 31) + 1);
      4: return i2bcd(r == 0 ? 12 : (r == 1 ? 2 : int'($urandom % 12) + 1));
      5: return i2bcd(r == 0 ? 99 : int'($urandom % 100));
      6: return 8'($urandom % 7);
      default: return 8'($urandom);
    endcase
  endfunction

  initial begin
    #4_000_000;
    n_bad++;
    $display("FAIL watchdog R0 act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    ms = 0; mm = 0; mh = 12; mpm = 0; mmode = 0; md = 1; mmo = 1; my = 0; mdw = 0; mcarry = 0;
    repeat (3) @(negedge clk_i);
    // R1 reset values
    chk("R1 sec", sec_o, 8'h00);
    chk("R1 hour", hour_o, 8'h12);
    chk("R1 date", date_o, 8'h01);
    chk("R1 month", month_o, 8'h01);
    chk("R1 dow", {5'b0, dow_o}, 8'h00);
    rst_ni = 1'b1;
    @(negedge clk_i);
    compare_all();

    // R6 leap February in year 00
    setr(5, 8'h00); setr(4, 8'h02); setr(3, 8'h28); edge_at(8'hA3);
    cyc(1, 0, 0, 0);
    chk("R6 feb29 y00", date_o, 8'h29);
    chk("R8 pulse", {7'b0, day_carry_o}, 8'h01);
    chk("R3 wrap", hour_o, 8'h80);
    cyc(0, 0, 0, 0);
    chk("R8 pulse end", {7'b0, day_carry_o}, 8'h00);
    edge_at(8'hA3); cyc(1, 0, 0, 0);
    chk("R6 mar01", month_o, 8'h03);
    chk("R6 mar01 date", date_o, 8'h01);
    // R6 non-leap year 01
    setr(5, 8'h01); setr(4, 8'h02); setr(3, 8'h28); edge_at(8'hA3);
    cyc(1, 0, 0, 0);
    chk("R6 y01 month", month_o, 8'h03);
    // R5 year end
    setr(5, 8'h99); setr(4, 8'h12); setr(3, 8'h31); edge_at(8'hA3);
    cyc(1, 0, 0, 0);
    chk("R5 year wrap", year_o, 8'h00);
    chk("R5 month wrap", month_o, 8'h01);
    // R5 thirty-day month
    setr(4, 8'h04); setr(3, 8'h30); edge_at(8'hA3);
    cyc(1, 0, 0, 0);
    chk("R5 apr30", month_o, 8'h05);
    // R3 BCD tens carry
    edge_at(8'h89); cyc(1, 0, 0, 0);
    chk("R3 09->10", hour_o, 8'h90);
    // R4 12-hour mode
    setr(3, 8'h05); edge_at(8'h31); cyc(1, 0, 0, 0);
    chk("R4 11pm->12am", hour_o, 8'h12);
    chk("R4 date adv", date_o, 8'h06);
    edge_at(8'h11); cyc(1, 0, 0, 0);
    chk("R4 11am->12pm", hour_o, 8'h32);
    chk("R4 no date adv", date_o, 8'h06);
    setr(1, 8'h59); setr(0, 8'h59); cyc(1, 0, 0, 0);
    chk("R4 12->01 pm", hour_o, 8'h21);
    // R9 write overrides tick, carry still propagates
    setr(1, 8'h10); setr(0, 8'h59);
    cyc(1, 1, 0, 8'h30);
    chk("R9 override sec", sec_o, 8'h30);
    chk("R9 carry min", min_o, 8'h11);
    setr(0, 8'hD9);
    chk("R9 mask", sec_o, 8'h59);
    cyc(0, 1, 7, 8'hFF);
    chk("R9 sel7", sec_o, 8'h59);
    // R10 hold
    for (int i = 0; i < 5; i++) begin
      cyc(0, 0, 0, 0);
      chk("R10 hold", sec_o, 8'h59);
    end

    // random mix
    for (int i = 0; i < 20000; i++) begin
      int sel;
      bit tk, we;
      tk  = ($urandom % 2) == 0;
      we  = ($urandom % 4) == 0;
      sel = int'($urandom % 8);
      cyc(tk, we, sel, rnd_val(sel));
    end

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule